// File: doc/BRIEF.md
# Stereo Idle-Input Mute Detector

This block sits beside the sample path of a two-channel DAC. It sees one left and one right sample word per frame, marked by a single-cycle frame strobe. It raises a mute flag for the downstream datapath once the input has stayed silent for a long run of frames. A word is silent when every bit of it has the same value, all ones or all zeros. Both channels must be silent in a frame for that frame to extend the run.

The run length is counted in frames by one saturating counter shared by the two channels. The counter has `IDLE_FRAMES` steps, 8192 by default, which gives a 13-bit counter. Any frame that carries a word with mixed bits, on either channel, drops the flag on the next clock and restarts the count from zero. There is no hysteresis. An active-low enable input switches the function on. While the enable is high, the flag is held low and the count is held at zero.

Top module: `idle_mute_det`

## Requirements
- R1: A frame counts as idle only when both the left word and the right word are each all-zeros or all-ones. A word with even one bit different from the rest, such as 0x000001 or 0xFFFFFE at 24 bits, makes the frame non-idle. A frame where only one channel is idle never leads to mute.
- R2: With enable low, `mute_o` goes high on the clock edge that samples the `IDLE_FRAMES`-th consecutive idle frame. It is seen one cycle after that frame, and not after `IDLE_FRAMES`-1 frames.
- R3: A non-idle frame on either channel clears `mute_o` on the next clock edge and restarts the count. Mute then needs a full `IDLE_FRAMES` idle frames again.
- R4: While `enable_ni` is high, `mute_o` is low from the next clock edge and the count is zero. After the enable returns low, a full `IDLE_FRAMES` idle frames are needed to mute.
- R5: The count saturates at its terminal value and does not wrap. Further idle frames keep `mute_o` high.
- R6: A word that flips between all-ones and all-zeros from one frame to the next still counts as idle.
- R7: Cycles with `frame_i` low change neither the count nor `mute_o`, whatever the sample inputs carry.
- R8: `rst_ni` low clears `mute_o` at once and clears the count. After reset a full run of `IDLE_FRAMES` idle frames is needed to mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_ni | input | 1 | Auto-mute enable, active low |
| frame_i | input | 1 | One-cycle strobe: left and right words valid |
| left_i | input | SAMPLE_W | Left sample word |
| right_i | input | SAMPLE_W | Right sample word |
| mute_o | output | 1 | Mute request to the datapath |

## Verification
The assertions assume that the sample words matter only in cycles where `frame_i` is high. They also assume that `enable_ni` and `frame_i` are clean synchronous levels, with no meaning given to X values. The stimulus changes every input half a cycle away from the sampling edge. It loads deliberately noisy words during strobe-free cycles, so that the rule that such cycles are ignored is actually exercised. Idle runs are driven to exactly one frame short of the threshold and then to the threshold. This is done with and without gaps between strobes, and after each kind of clear: a noisy word, the enable and a reset.

// File: rtl/idle_mute_pkg.sv
package idle_mute_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} ch_e;
endpackage

// File: rtl/idle_word_chk.sv
module idle_word_chk #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] word_i,
  output logic         stuck_o
);
  // all bits equal: all ones or all zeros
  assign stuck_o = (&word_i) | ~(|word_i);
endmodule

// File: rtl/frame_run_ctr.sv
module frame_run_ctr #(
  parameter int unsigned RUN_LEN = 8192,
  parameter int unsigned CNT_W   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !full_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/mute_flag.sv
module mute_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic mute_o
);
  logic mute_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mute_q <= 1'b0;
    else if (clr_i)  mute_q <= 1'b0;
    else if (set_i)  mute_q <= 1'b1;
  end

  assign mute_o = mute_q;
endmodule

// File: rtl/idle_mute_det.sv
module idle_mute_det
  import idle_mute_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned IDLE_FRAMES = 8192
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_ni,
  input  logic                frame_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                mute_o
);
  localparam int unsigned CNT_W = (IDLE_FRAMES > 1) ? $clog2(IDLE_FRAMES) : 1;

  logic [SAMPLE_W-1:0] ch_word [NUM_CH];
  logic [NUM_CH-1:0]   ch_stuck;
  logic                both_idle;
  logic                run_clr;
  logic                run_inc;
  logic                run_full;
  logic [CNT_W-1:0]    run_cnt;

  assign ch_word[CH_LEFT]  = left_i;
  assign ch_word[CH_RIGHT] = right_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    idle_word_chk #(.W(SAMPLE_W)) u_stuck (
      .word_i  (ch_word[c]),
      .stuck_o (ch_stuck[c])
    );
  end

  assign both_idle = &ch_stuck;
  assign run_clr   = enable_ni | (frame_i & ~both_idle);
  assign run_inc   = frame_i & both_idle;

  frame_run_ctr #(.RUN_LEN(IDLE_FRAMES), .CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (run_clr),
    .inc_i  (run_inc),
    .cnt_o  (run_cnt),
    .full_o (run_full)
  );

  // counter already at terminal: this frame completes the run
  mute_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (run_clr),
    .set_i  (run_inc & run_full),
    .mute_o (mute_o)
  );
endmodule

// File: rtl/idle_mute_chk.sv
module idle_mute_chk #(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned IDLE_FRAMES = 8192,
  parameter int unsigned CNT_W       = 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_ni,
  input logic                frame_i,
  input logic [SAMPLE_W-1:0] left_i,
  input logic [SAMPLE_W-1:0] right_i,
  input logic [CNT_W-1:0]    cnt,
  input logic                mute_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(IDLE_FRAMES - 1);

  logic l_ok, r_ok;
  assign l_ok = (left_i  == '0) || (left_i  == '1);
  assign r_ok = (right_i == '0) || (right_i == '1);

  // R4
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_ni |=> (!mute_o && cnt == '0));

  // R3
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !(l_ok && r_ok)) |=> (!mute_o && cnt == '0));

  // R7
  no_frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !enable_ni) |=> ($stable(mute_o) && $stable(cnt)));

  // R2
  mute_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_o) |-> ($past(frame_i) && $past(cnt) == TOP));

  // R5
  sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> (cnt == TOP));

  // R5
  mute_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o && frame_i && !enable_ni && l_ok && r_ok) |=> mute_o);
endmodule

bind idle_mute_det idle_mute_chk #(
  .SAMPLE_W    (SAMPLE_W),
  .IDLE_FRAMES (IDLE_FRAMES),
  .CNT_W       (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_ni (enable_ni),
  .frame_i   (frame_i),
  .left_i    (left_i),
  .right_i   (right_i),
  .cnt       (run_cnt),
  .mute_o    (mute_o)
);

// File: tb/tb_idle_mute_det.sv
module tb_idle_mute_det;
  localparam int CLK_P = 10;
  localparam int W     = 24;
  localparam int T     = 8192;
  localparam int WDOG  = 150000;

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] NZ_A = 24'h5A3C01;
  localparam logic [W-1:0] LO1  = 24'h000001;
  localparam logic [W-1:0] HI0  = 24'hFFFFFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_n = 1'b0;
  logic frm = 1'b0;
  logic [W-1:0] l_w = '0;
  logic [W-1:0] r_w = '0;
  logic mute;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  bit    exp_q[$];
  string tag_q[$];

  int m_cnt = 0;
  bit m_mute = 0;

  always #(CLK_P/2) clk = ~clk;

  idle_mute_det #(.SAMPLE_W(W), .IDLE_FRAMES(T)) dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_ni(en_n), .frame_i(frm),
    .left_i(l_w), .right_i(r_w), .mute_o(mute)
  );

  function automatic bit stuck(logic [W-1:0] w);
    return (w == ZERO) || (w == ONES);
  endfunction

  // driver: apply one cycle, push the expected flag
  task automatic drive(bit rs, bit en, bit f, logic [W-1:0] l, logic [W-1:0] r, string tag);
    @(negedge clk);
    rst_n = rs; en_n = en; frm = f; l_w = l; r_w = r;
    @(posedge clk);
    if (!rs || en) begin
      m_cnt = 0; m_mute = 0;
    end else if (f) begin
      if (!(stuck(l) && stuck(r))) begin
        m_cnt = 0; m_mute = 0;
      end else if (m_cnt == T-1) m_mute = 1;
      else m_cnt++;
    end
    exp_q.push_back(m_mute);
    tag_q.push_back(tag);
  endtask

  task automatic idle_run(int n, bit alt, int gap, string tag);
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] w;
      w = (alt && i[0]) ? ONES : ZERO;
      drive(1, 0, 1, w, alt ? ~w : w, tag);
      for (int g = 0; g < gap; g++) drive(1, 0, 0, NZ_A, LO1, "R7 gap");
    end
  endtask

  // monitor: compare away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (mute !== e) begin
          n_bad++;
          $display("FAIL %s: mute_o=%b expected %b (cycle %0d)", t, mute, e, cyc);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG && !done) begin
      n_bad++;
      $display("FAIL watchdog: expired at cycle %0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    for (int i = 0; i < 3; i++) drive(0, 0, 1, ZERO, ZERO, "R8 reset");
    // R2 exact threshold, zeros
    idle_run(T-1, 0, 0, "R2 below threshold");
    idle_run(1, 0, 0, "R2 threshold");
    // R5 saturation
    for (int i = 0; i < 20; i++) drive(1, 0, 1, ONES, ONES, "R5 saturate");
    // R7 strobe-free noise while muted
    for (int i = 0; i < 5; i++) drive(1, 0, 0, NZ_A, HI0, "R7 no frame");
    // R1/R3 single-bit-off left word releases
    drive(1, 0, 1, LO1, ZERO, "R1 R3 left off-by-one");
    idle_run(T-1, 0, 0, "R3 recount below");
    idle_run(1, 0, 0, "R3 recount hit");
    // R3 right channel releases
    drive(1, 0, 1, ONES, HI0, "R1 R3 right off-by-one");
    // R1 only one channel idle
    for (int i = 0; i < 10; i++) drive(1, 0, 1, ZERO, NZ_A, "R1 one channel idle");
    // R6 alternating ones/zeros, with gaps (R7)
    idle_run(100, 1, 1, "R6 R7 alternating gapped");
    idle_run(T-101, 1, 0, "R6 alternating below");
    idle_run(1, 1, 0, "R6 alternating hit");
    // R4 enable off
    for (int i = 0; i < 4; i++) drive(1, 1, 1, ZERO, ZERO, "R4 disabled");
    idle_run(T-1, 0, 0, "R4 recount below");
    idle_run(1, 0, 0, "R4 recount hit");
    // R8 reset while muted
    drive(0, 0, 1, ZERO, ZERO, "R8 reset muted");
    idle_run(T-1, 0, 0, "R8 recount below");
    idle_run(1, 0, 0, "R8 recount hit");
    drive(1, 0, 0, ZERO, ZERO, "R7 idle tail");
    drive(1, 0, 0, ZERO, ZERO, "R7 idle tail");
    @(posedge clk);
    #(CLK_P/2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule